// File: doc/BRIEF.md
# Reset Cause Control Register

This block keeps a single 32-bit register that tells software why the system last came out of reset. It also lets software ask for a new reset. Five bits at the top of the word are live:

| Bit | Meaning | Write behaviour |
|-----|---------|-----------------|
| 31 | cold-start cause | write one to clear |
| 30 | software full restart | write one to set |
| 29 | software warm restart | write one to set |
| 28 | button full restart | write one to clear |
| 27 | button warm restart | write one to clear |

Writing a one to bit 30 or bit 29 raises a one-cycle system reset request on the cycle after the write.

A small saturating counter counts the system resets seen since power-up. When a system reset arrives and that counter is zero, the reset counts as a cold start: the register is reloaded with only bit 31 set. A software full-restart request zeroes the counter, so the reset that follows is treated as a cold start again. A warm-restart request leaves the counter alone.

The register sits on a simple memory-mapped bus. It decodes one 8-byte window and answers only on the upper word of that window. Reads return data one cycle after the read strobe, together with a valid flag. The system reset itself reaches the block as a synchronous `sysRst` pulse. A button reset is reported on `rstCause` in the same cycle as that pulse.

Top module: `resetCauseReg`

## Requirements
- R1: After the power-up reset (`pwrRstN` low), the register reads 0x00000000 and the reset counter is zero. The first `sysRst` that follows loads 0x80000000.
- R2: Only bits 31..27 exist. Writes to bits 26..0 have no effect, and those bits always read as zero.
- R3: Writing a one to bit 31, 28 or 27 clears that bit. Writing a zero to it leaves the bit unchanged.
- R4: Writing a one to bit 30 or 29 sets that bit. Writing a zero to it leaves the bit unchanged.
- R5: A write with bit 30 or bit 29 set raises `sysRstReq` for exactly one cycle, on the cycle after the write. Setting both bits gives a single pulse.
- R6: Writing a one to bit 30 zeroes the reset counter. The next `sysRst` therefore reloads the register with 0x80000000 alone. This still holds when bit 29 is written in the same write.
- R7: Writing a one to bit 29 without bit 30 leaves the counter unchanged. A later `sysRst` keeps the register contents, so bit 29 stays set.
- R8: The register answers only when `busAddr[15:3]` equals 0xF020>>3 and `busAddr[2]` is 1 (byte address 0xF024). Address 0xF020 and every other address read as zero, and writes to them have no effect.
- R9: A `sysRst` with a nonzero counter keeps the register contents. It also sets bit 28 when `rstCause[0]` is 1 and bit 27 when `rstCause[1]` is 1. A `sysRst` with a zero counter loads 0x80000000 regardless of `rstCause`.
- R10: The reset counter saturates at its maximum value and never wraps back to zero. Any number of `sysRst` pulses without a full-restart request therefore never gives a cold-start reload.
- R11: A bus write in the same cycle as `sysRst` is discarded. It changes no bit and raises no `sysRstReq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| pwrRstN | input | 1 | Asynchronous active-low power-up reset; clears the register and the counter |
| sysRst | input | 1 | Synchronous system reset event to be recorded |
| rstCause | input | 2 | Button cause sampled with `sysRst`: bit 0 is full restart, bit 1 is warm restart |
| busAddr | input | ADDR_W | Byte address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdEn | input | 1 | Read strobe |
| busRdValid | output | 1 | Read data valid, one cycle after `busRdEn` |
| busRdData | output | 32 | Read data |
| sysRstReq | output | 1 | One-cycle system reset request |

## Verification
The assertions check several rules on every cycle:
- a `sysRstReq` pulse always traces back to a decoded soft-restart write;
- no pulse follows a `sysRst` cycle;
- a zero-counter reset reloads the cold-start value;
- a warm restart or a non-cold reset preserves the software bits;
- the counter stays at its ceiling.

Only the bench scenarios can show the rest:
- the exact read values after each mixed set/clear write;
- that 0xF020 and neighbouring addresses are dead;
- that button causes accumulate;
- that a full restart re-arms the cold-start reload only on the following reset.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
  localparam int LIVE_BITS = 5;
  localparam int LIVE_LSB  = 27;
  // live bit indices inside the 5-bit field (field bit 4 = word bit 31)
  localparam int B_COLD    = 4;
  localparam int B_SWFULL  = 3;
  localparam int B_SWWARM  = 2;
  localparam int B_BTFULL  = 1;
  localparam int B_BTWARM  = 0;
  localparam logic [LIVE_BITS-1:0] CLR_MASK = 5'b10011;
  localparam logic [LIVE_BITS-1:0] SET_MASK = 5'b01100;
  localparam logic [LIVE_BITS-1:0] COLD_VAL = 5'b10000;

  typedef struct packed {
    logic                 wrStb;
    logic [LIVE_BITS-1:0] wBits;
    logic                 softFull;
    logic                 softWarm;
  } rcrStrobe_t;
endpackage

// File: rtl/rcr_ctrl.sv
module rcr_ctrl
  import rcr_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter logic [15:0]     REG_BASE = 16'hF020
) (
  input  logic                 clk,
  input  logic                 pwrRstN,
  input  logic                 sysRst,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic [31:0]          busWrData,
  input  logic                 busRdEn,
  input  logic [LIVE_BITS-1:0] regBits,
  output rcrStrobe_t           stb,
  output logic                 busRdValid,
  output logic [31:0]          busRdData,
  output logic                 sysRstReq
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(REG_BASE);

  logic regHit;
  assign regHit = (busAddr[ADDR_W-1:3] == BASE_A[ADDR_W-1:3]) && busAddr[2];

  always_comb begin
    stb.wrStb    = busWrEn && regHit && !sysRst;
    stb.wBits    = busWrData[31:LIVE_LSB];
    stb.softFull = stb.wrStb && stb.wBits[B_SWFULL];
    stb.softWarm = stb.wrStb && !stb.wBits[B_SWFULL] && stb.wBits[B_SWWARM];
  end

  always_ff @(posedge clk or negedge pwrRstN) begin
    if (!pwrRstN) begin
      sysRstReq  <= 1'b0;
      busRdValid <= 1'b0;
      busRdData  <= '0;
    end else begin
      sysRstReq  <= stb.softFull || stb.softWarm;
      busRdValid <= busRdEn;
      busRdData  <= (busRdEn && regHit) ? {regBits, {LIVE_LSB{1'b0}}} : 32'h0;
    end
  end

  // R5
  req_origin_chk: assert property (@(posedge clk) disable iff (!pwrRstN)
    sysRstReq |-> $past(busWrEn && regHit && !sysRst &&
                        (busWrData[30] || busWrData[29])));

  // R11
  rst_blocks_req_chk: assert property (@(posedge clk) disable iff (!pwrRstN)
    sysRst |=> !sysRstReq);
endmodule

// File: rtl/rcr_datapath.sv
module rcr_datapath
  import rcr_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic                 clk,
  input  logic                 pwrRstN,
  input  logic                 sysRst,
  input  logic [1:0]           rstCause,
  input  rcrStrobe_t           stb,
  output logic [LIVE_BITS-1:0] regBits
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0]     rstCnt;
  logic [LIVE_BITS-1:0] btnBits;

  always_comb begin
    btnBits           = '0;
    btnBits[B_BTFULL] = rstCause[0];
    btnBits[B_BTWARM] = rstCause[1];
  end

  always_ff @(posedge clk or negedge pwrRstN) begin
    if (!pwrRstN) begin
      regBits <= '0;
      rstCnt  <= '0;
    end else if (sysRst) begin
      regBits <= (rstCnt == '0) ? COLD_VAL : (regBits | btnBits);
      if (rstCnt != CNT_MAX) rstCnt <= rstCnt + 1'b1;
    end else if (stb.wrStb) begin
      regBits <= (regBits & ~(stb.wBits & CLR_MASK)) | (stb.wBits & SET_MASK);
      if (stb.softFull) rstCnt <= '0;
    end
  end

  // R1
  cold_load_chk: assert property (@(posedge clk) disable iff (!pwrRstN)
    (sysRst && rstCnt == '0) |=> regBits == COLD_VAL);

  // R6
  full_rearm_chk: assert property (@(posedge clk) disable iff (!pwrRstN)
    stb.softFull |=> rstCnt == '0);

  // R7
  warm_keep_chk: assert property (@(posedge clk) disable iff (!pwrRstN)
    (sysRst && rstCnt != '0) |=> regBits[B_SWWARM] == $past(regBits[B_SWWARM]));

  // R3
  cold_clear_chk: assert property (@(posedge clk) disable iff (!pwrRstN)
    (stb.wrStb && stb.wBits[B_COLD]) |=> !regBits[B_COLD]);

  // R10
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!pwrRstN)
    (rstCnt == CNT_MAX && !stb.softFull) |=> rstCnt == CNT_MAX);
endmodule

// File: rtl/resetCauseReg.sv
module resetCauseReg
  import rcr_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] REG_BASE = 16'hF020,
  parameter int          CNT_W    = 4
) (
  input  logic              clk,
  input  logic              pwrRstN,
  input  logic              sysRst,
  input  logic [1:0]        rstCause,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  input  logic              busRdEn,
  output logic              busRdValid,
  output logic [31:0]       busRdData,
  output logic              sysRstReq
);
  rcrStrobe_t           stb;
  logic [LIVE_BITS-1:0] regBits;

  rcr_ctrl #(.ADDR_W(ADDR_W), .REG_BASE(REG_BASE)) uCtrl (
    .clk(clk), .pwrRstN(pwrRstN), .sysRst(sysRst),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdEn(busRdEn), .regBits(regBits), .stb(stb),
    .busRdValid(busRdValid), .busRdData(busRdData), .sysRstReq(sysRstReq)
  );

  rcr_datapath #(.CNT_W(CNT_W)) uData (
    .clk(clk), .pwrRstN(pwrRstN), .sysRst(sysRst), .rstCause(rstCause),
    .stb(stb), .regBits(regBits)
  );
endmodule

// File: tb/resetCauseReg_test.sv
module resetCauseReg_test;
  logic        clk = 1'b0;
  logic        pwrRstN = 1'b0;
  logic        sysRst = 1'b0;
  logic [1:0]  rstCause = 2'b00;
  logic [15:0] busAddr = 16'h0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = 32'h0;
  logic        busRdEn = 1'b0;
  logic        busRdValid;
  logic [31:0] busRdData;
  logic        sysRstReq;

  int total = 0;
  int bad = 0;
  int pulseCnt = 0;
  int pulseRun = 0;
  int maxRun = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  localparam logic [15:0] RA = 16'hF024;

  always #2 clk = ~clk;

  resetCauseReg uut (
    .clk(clk), .pwrRstN(pwrRstN), .sysRst(sysRst), .rstCause(rstCause),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdEn(busRdEn), .busRdValid(busRdValid), .busRdData(busRdData),
    .sysRstReq(sysRstReq)
  );

  // monitor: read scoreboard and pulse tracking
  always @(negedge clk) begin
    if (pwrRstN && busRdValid) begin
      total++;
      if (expQ.size() == 0) begin
        bad++;
        $display("FAIL read-order: unexpected data act=%h exp=none", busRdData);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (busRdData !== e) begin
          bad++;
          $display("FAIL %s: act=%h exp=%h", t, busRdData, e);
        end
      end
    end
    if (sysRstReq) begin
      pulseCnt++;
      pulseRun++;
      if (pulseRun > maxRun) maxRun = pulseRun;
    end else pulseRun = 0;
  end

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    expQ.push_back(e); tagQ.push_back(t);
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic srst(input logic [1:0] c);
    @(negedge clk);
    sysRst = 1'b1; rstCause = c;
    @(negedge clk);
    sysRst = 1'b0; rstCause = 2'b00;
  endtask

  task automatic chkPulses(input int e, input string t);
    repeat (2) @(negedge clk);
    total++;
    if (pulseCnt != e) begin
      bad++;
      $display("FAIL %s: pulses act=%0d exp=%0d", t, pulseCnt, e);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    pwrRstN = 1'b1;
    rd(RA, 32'h0, "R1 power-up value");
    srst(2'b11);
    rd(RA, 32'h8000_0000, "R1 first reset cold load");
    rd(RA, 32'h8000_0000, "R9 zero count ignores cause");
    chkPulses(0, "R1 no pulse at reset");

    rd(16'hF020, 32'h0, "R8 lower word reads zero");
    rd(16'hF02C, 32'h0, "R8 neighbour reads zero");
    wr(16'hF02C, 32'hFFFF_FFFF);
    wr(16'hF020, 32'hFFFF_FFFF);
    wr(16'h7024, 32'hFFFF_FFFF);
    rd(RA, 32'h8000_0000, "R8 other writes ignored");
    chkPulses(0, "R8 no pulse from other addresses");

    wr(RA, 32'h07FF_FFFF);
    rd(RA, 32'h8000_0000, "R2 low bits not stored");
    wr(RA, 32'h0000_0000);
    rd(RA, 32'h8000_0000, "R3 zero write keeps cold bit");
    wr(RA, 32'h8000_0000);
    rd(RA, 32'h0, "R3 clear cold bit");

    srst(2'b01);
    rd(RA, 32'h1000_0000, "R9 button full cause");
    srst(2'b10);
    rd(RA, 32'h1800_0000, "R9 button causes accumulate");
    wr(RA, 32'h0800_0000);
    rd(RA, 32'h1000_0000, "R3 clear bit 27 only");
    wr(RA, 32'h1000_0000);
    rd(RA, 32'h0, "R3 clear bit 28");

    wr(RA, 32'h2000_0000);
    chkPulses(1, "R5 warm request pulse");
    rd(RA, 32'h2000_0000, "R4 set warm bit");
    wr(RA, 32'h0);
    rd(RA, 32'h2000_0000, "R4 zero keeps set bit");
    srst(2'b00);
    rd(RA, 32'h2000_0000, "R7 warm keeps counter");

    wr(RA, 32'h4000_0000);
    chkPulses(2, "R5 full request pulse");
    rd(RA, 32'h6000_0000, "R4 set full bit");
    srst(2'b00);
    rd(RA, 32'h8000_0000, "R6 full rearms cold load");

    wr(RA, 32'h6000_0000);
    chkPulses(3, "R5 both bits one pulse");
    rd(RA, 32'hE000_0000, "R4 both set");
    srst(2'b00);
    rd(RA, 32'h8000_0000, "R6 full wins over warm");

    // R11: write together with sysRst is dropped (counter is nonzero)
    @(negedge clk);
    busAddr = RA; busWrData = 32'hC000_0000; busWrEn = 1'b1; sysRst = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; sysRst = 1'b0;
    chkPulses(3, "R11 no pulse with sysRst");
    rd(RA, 32'h8000_0000, "R11 write discarded");

    // R10: saturate the counter, then show no cold reload
    for (int i = 0; i < 20; i++) srst(2'b00);
    wr(RA, 32'h8000_0000);
    srst(2'b00);
    rd(RA, 32'h0, "R10 saturated counter no cold load");

    repeat (3) @(negedge clk);
    total++;
    if (maxRun != 1) begin
      bad++;
      $display("FAIL R5 pulse width: act=%0d exp=1", maxRun);
    end
    total++;
    if (expQ.size() != 0) begin
      bad++;
      $display("FAIL read-count: act=%0d pending exp=0", expQ.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule